// File: doc/BRIEF.md
# USB Full-Speed Host Frame Timer

This block keeps time for a full-speed USB host. A 16-bit down-counter shows how many PHY clocks are left in the current frame. A 16-bit frame number counts the frames. Both values are packed into one 32-bit status word. Each time the counter runs out, it reloads from a programmable frame-interval register. On that reload the frame number steps and a one-clock start-of-frame pulse is raised.

The block also guards writes to the transmit FIFO. If a write request arrives late in a frame, while the remaining time is below a programmable threshold, it is not granted at once. It is held until the next start-of-frame and granted in that cycle, so no write can straddle a frame boundary and be lost. Only one write can be held at a time. While one is held, the ready output stays low, which back-pressures the requester.

A frame lasts interval+1 clocks: the counter runs from the interval value down to zero, then reloads on the next cycle. The interval register is written through a simple strobe-and-data port.

Top module: `usb_frame_timer`

## Requirements
- R1: The status word carries the remaining-time counter in bits 31..16 and the frame number in bits 15..0.
- R2: After reset the status word reads 0, the start-of-frame pulse is low, the ready output is high, and the frame-interval register holds 60000.
- R3: While running, the remaining-time counter drops by one on every clock until it reaches zero.
- R4: On the clock after the counter reads zero, the counter reloads with the interval value, the frame number rises by one, and the start-of-frame pulse is high for exactly that one clock. Pulses are therefore interval+1 clocks apart.
- R5: A write to the interval register leaves the current frame unchanged and is used from the next reload on.
- R6: While the run input is low, the counter and the frame number hold and no start-of-frame pulse occurs. On the first clock with run high, the counter loads the interval value and the frame number becomes 0, with no pulse.
- R7: The frame number is 16 bits wide and wraps from 0xFFFF to 0 on the next reload.
- R8: A write request made while ready is high and the remaining time is at or above the threshold is granted combinationally in the same cycle.
- R9: A write request made while ready is high and the remaining time is below the threshold is not granted. It is held, and the grant output is raised in the next start-of-frame cycle, with no grant in between.
- R10: While a write is held, ready is low and further requests get no grant. Ready returns high on the clock after the held write is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Enables frame counting |
| ivl_wr | input | 1 | Write strobe for the frame-interval register |
| ivl_data | input | 16 | New frame-interval value |
| guard_thresh | input | 16 | End-of-frame window threshold in clocks |
| wr_req | input | 1 | Transmit-FIFO write request |
| wr_ready | output | 1 | High when a new request can be taken |
| wr_grant | output | 1 | Write may go to the FIFO this cycle |
| status | output | 32 | {remaining time, frame number} |
| sof | output | 1 | One-clock start-of-frame pulse |

## Verification
A corrupted remaining-time counter appears in status bits 31..16 on the very next clock, because each sample must be exactly one less than the one before. A wrong reload shows up in the start-of-frame cycle as a wrong value or a wrong spacing between pulses. A stuck or lost held-write flag shows at the ports within one frame: either ready stays low past the start-of-frame, or the grant never comes. A grant that arrives too early is seen in the same cycle as the request that was meant to be held.

// File: rtl/uft_pkg.sv
// Shared widths and the packed status layout of the frame timer.
// Assumes a full-speed host whose frame counter and frame number fit 16 bits.
package uft_pkg;
    localparam int TIME_W  = 16;
    localparam int FNUM_W  = 16;
    localparam int STAT_W  = TIME_W + FNUM_W;
    localparam logic [TIME_W-1:0] IVL_RESET = 16'd60000;

    typedef struct packed {
        logic [TIME_W-1:0] remaining;
        logic [FNUM_W-1:0] frame;
    } uft_status_t;
endpackage

// File: rtl/uft_interval_reg.sv
// Frame-interval register: holds the reload value of the frame counter.
// The counter samples it only at a reload, so a write never cuts a frame short.
module uft_interval_reg #(
    parameter int                TW        = 16,
    parameter logic [TW-1:0]     RESET_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [TW-1:0] data,
    output logic [TW-1:0] value
);
    // Capture a new interval on the write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  value <= RESET_VAL;
        else if (wr) value <= data;
    end
endmodule

// File: rtl/uft_frame_counter.sv
// Remaining-time down-counter and frame number with a start-of-frame pulse.
// Assumes run is synchronous to clk; a frame lasts reload_val+1 clocks.
module uft_frame_counter #(
    parameter int TW = 16,
    parameter int FW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [TW-1:0] reload_val,
    output logic [TW-1:0] remaining,
    output logic [FW-1:0] frame,
    output logic          sof
);
    logic active;

    // Count down, reload after zero, and restart the frame number when run rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remaining <= '0;
            frame     <= '0;
            sof       <= 1'b0;
            active    <= 1'b0;
        end else begin
            sof    <= 1'b0;
            active <= run;
            if (run) begin
                if (!active) begin
                    remaining <= reload_val;
                    frame     <= '0;
                end else if (remaining == '0) begin
                    remaining <= reload_val;
                    frame     <= frame + 1'b1;
                    sof       <= 1'b1;
                end else begin
                    remaining <= remaining - 1'b1;
                end
            end
        end
    end

    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (run && active && remaining != '0) |=> remaining == TW'($past(remaining) - 1'b1)); // R3
    AST_SOF_AFTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> $past(remaining) == '0); // R4
    AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> frame == FW'($past(frame) + 1'b1)); // R7
    AST_SOF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> !sof || remaining == '0); // R4
    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(remaining) && $stable(frame) && !sof); // R6
endmodule

// File: rtl/uft_write_guard.sv
// End-of-frame write guard: grants FIFO writes at once outside the window,
// otherwise holds one request until the next start-of-frame pulse.
// Assumes the requester keeps wr_req high until it sees wr_ready.
module uft_write_guard #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] remaining,
    input  logic [TW-1:0] thresh,
    input  logic          sof,
    input  logic          wr_req,
    output logic          wr_ready,
    output logic          wr_grant
);
    logic pending;
    logic in_window;

    // Decide between an immediate grant, a deferral, and the release of a held write.
    always_comb begin
        in_window = remaining < thresh;
        wr_ready  = !pending;
        wr_grant  = (pending && sof) || (wr_req && !pending && !in_window);
    end

    // Track the single held write.
    always_ff @(posedge clk) begin
        if (!rst_n)                                pending <= 1'b0;
        else if (pending && sof)                   pending <= 1'b0;
        else if (wr_req && !pending && in_window)  pending <= 1'b1;
    end

    AST_HELD_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !sof) |-> !wr_grant); // R9
    AST_HELD_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !sof) |=> pending); // R10
    AST_RELEASE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && sof) |=> wr_ready); // R10
endmodule

// File: rtl/usb_frame_timer.sv
// Full-speed USB host frame timer with an end-of-frame FIFO write guard.
// Composes the interval register, the frame counter and the write guard,
// and packs remaining time and frame number into one status word.
module usb_frame_timer
    import uft_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              ivl_wr,
    input  logic [TIME_W-1:0] ivl_data,
    input  logic [TIME_W-1:0] guard_thresh,
    input  logic              wr_req,
    output logic              wr_ready,
    output logic              wr_grant,
    output logic [STAT_W-1:0] status,
    output logic              sof
);
    logic [TIME_W-1:0] ivl_value;
    logic [TIME_W-1:0] remaining;
    logic [FNUM_W-1:0] frame;
    uft_status_t       stat;

    uft_interval_reg #(.TW(TIME_W), .RESET_VAL(IVL_RESET)) u_ivl (
        .clk(clk), .rst_n(rst_n), .wr(ivl_wr), .data(ivl_data), .value(ivl_value)
    );

    uft_frame_counter #(.TW(TIME_W), .FW(FNUM_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .reload_val(ivl_value),
        .remaining(remaining), .frame(frame), .sof(sof)
    );

    uft_write_guard #(.TW(TIME_W)) u_guard (
        .clk(clk), .rst_n(rst_n), .remaining(remaining), .thresh(guard_thresh),
        .sof(sof), .wr_req(wr_req), .wr_ready(wr_ready), .wr_grant(wr_grant)
    );

    // Pack the readable status word.
    always_comb begin
        stat.remaining = remaining;
        stat.frame     = frame;
        status         = stat;
    end

    AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> status[31:16] == $past(ivl_value)); // R1
endmodule

// File: tb/usb_frame_timer_test.sv
module usb_frame_timer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n, run, ivl_wr, wr_req;
    logic [15:0] ivl_data, guard_thresh;
    logic        wr_ready, wr_grant, sof;
    logic [31:0] status;
    int          total = 0;
    int          bad   = 0;
    bit          done  = 0;

    usb_frame_timer uut (
        .clk(clk), .rst_n(rst_n), .run(run), .ivl_wr(ivl_wr), .ivl_data(ivl_data),
        .guard_thresh(guard_thresh), .wr_req(wr_req), .wr_ready(wr_ready),
        .wr_grant(wr_grant), .status(status), .sof(sof)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wait_sof(output int cycles);
        cycles = 0;
        do begin
            step(1);
            cycles++;
        end while (!sof && cycles < 200);
    endtask

    task automatic restart(input logic [15:0] ivl);
        run = 1'b0; ivl_wr = 1'b1; ivl_data = ivl;
        step(1);
        ivl_wr = 1'b0; run = 1'b1;
        step(1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; run = 1'b0; ivl_wr = 1'b0; ivl_data = '0;
        guard_thresh = 16'd3; wr_req = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
        check("R2 status", status, 32'h0);
        check("R2 sof", {31'b0, sof}, 32'h0);
        check("R2 ready", {31'b0, wr_ready}, 32'h1);
    endtask

    task automatic t_default_and_hold();
        run = 1'b1;
        step(1);
        check("R2 R6 default load", status, {16'd60000, 16'd0});
        step(1);
        check("R3 decrement R1 layout", status, {16'd59999, 16'd0});
        step(1);
        check("R3 decrement", status[31:16], 32'd59998);
        run = 1'b0;
        step(2);
        check("R6 hold", status, {16'd59998, 16'd0});
        check("R6 no sof", {31'b0, sof}, 32'h0);
    endtask

    task automatic t_reload();
        int n;
        int gap;
        restart(16'd9);
        check("R6 start load", status, {16'd9, 16'd0});
        check("R6 no sof on start", {31'b0, sof}, 32'h0);
        step(9);
        check("R3 reaches zero", status, {16'd0, 16'd0});
        check("R4 no sof at zero", {31'b0, sof}, 32'h0);
        step(1);
        check("R4 reload", status, {16'd9, 16'd1});
        check("R4 sof", {31'b0, sof}, 32'h1);
        step(1);
        check("R4 sof one clock", {31'b0, sof}, 32'h0);
        check("R4 after reload", status[31:16], 32'd8);
        wait_sof(n);
        gap = n + 1;
        check("R4 spacing interval+1", gap, 32'd10);
        check("R4 frame step", status[15:0], 32'd2);
    endtask

    task automatic t_interval_write();
        int n;
        step(2);
        ivl_wr = 1'b1; ivl_data = 16'd4;
        step(1);
        ivl_wr = 1'b0;
        check("R5 frame unaffected", status[31:16], 32'd6);
        wait_sof(n);
        check("R5 old frame length", n, 32'd7);
        check("R5 new reload", status[31:16], 32'd4);
        wait_sof(n);
        check("R5 new spacing", n, 32'd5);
    endtask

    task automatic t_guard();
        int guard_n;
        restart(16'd9);
        guard_thresh = 16'd3;
        wr_req = 1'b1; #1;
        check("R8 immediate grant", {31'b0, wr_grant}, 32'h1);
        wr_req = 1'b0;
        step(6);
        check("R8 at threshold rem", status[31:16], 32'd3);
        wr_req = 1'b1; #1;
        check("R8 grant at threshold", {31'b0, wr_grant}, 32'h1);
        wr_req = 1'b0;
        step(1);
        wr_req = 1'b1; #1;
        check("R9 no grant in window", {31'b0, wr_grant}, 32'h0);
        check("R10 ready before defer", {31'b0, wr_ready}, 32'h1);
        step(1);
        wr_req = 1'b0; #1;
        check("R10 ready low held", {31'b0, wr_ready}, 32'h0);
        check("R9 no early grant", {31'b0, wr_grant}, 32'h0);
        wr_req = 1'b1; #1;
        check("R10 backpressure", {31'b0, wr_grant}, 32'h0);
        wr_req = 1'b0;
        guard_n = 0;
        step(1);
        while (!sof && guard_n < 50) begin
            if (wr_grant) check("R9 grant before sof", 32'h1, 32'h0);
            step(1);
            guard_n++;
        end
        check("R9 sof reached", {31'b0, sof}, 32'h1);
        check("R9 released grant", {31'b0, wr_grant}, 32'h1);
        step(1);
        check("R10 ready restored", {31'b0, wr_ready}, 32'h1);
        check("R10 no repeat grant", {31'b0, wr_grant}, 32'h0);
    endtask

    task automatic t_wrap();
        int n;
        restart(16'd0);
        check("R6 frame zero", status, 32'h0);
        n = 0;
        while (status[15:0] != 16'hFFFF && n < 70000) begin
            step(1);
            n++;
        end
        check("R7 reach max", status[15:0], 32'hFFFF);
        step(1);
        check("R7 wrap", status[15:0], 32'h0);
        check("R7 sof on wrap", {31'b0, sof}, 32'h1);
    endtask

    initial begin
        t_reset();
        t_default_and_hold();
        t_reload();
        t_interval_write();
        t_guard();
        t_wrap();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule